// File: doc/BRIEF.md
# Strobed Direct Digital Sine Source

This block generates sampled sine test tones for a signal-processing chain running from one fast system clock. A fractional rate accumulator adds a rate code on every clock. Each time that sum wraps past the top of its range, the block emits a one-clock sample strobe. The average strobe rate is therefore `rate_code × F_clk / 2^32`. For example, a rate code of 4294967 on a 50 MHz clock gives a sample rate close to 50 kHz.

On every strobe a second accumulator, the tone phase, advances by the tone code. The tone frequency is `tone_code × F_sample / 2^32`, a step of about 11.64 µHz at 50 kHz. At that sample rate, codes 171798692, 300647711 and 335007449 give 2000 Hz, 3500 Hz and 3900 Hz.

The top 14 phase bits select a word of a 16384-point sine table of 10-bit offset-binary samples centred on 512. Only one quarter of the wave is stored; the other three quarters are rebuilt by folding. The sample is presented both as the unsigned code and as a two's-complement copy. Either code can change at any clock and takes effect from the next strobe, with no jump in phase.

Top module: `tone_dds`

## Requirements
- R1: `sample_stb_o` is high for exactly one clock on each wrap of the rate accumulator. After reset, the number of strobes seen in the first W clocks is floor(W × rate_code / 2^32). While the rate code stays below 2^31, no two strobes are adjacent.
- R2: A rate code of 4294967 yields exactly 19 strobes in the first 20000 clocks after reset.
- R3: The tone phase starts at 0 after reset and advances by the tone code, modulo 2^32, only at a clock that raises the strobe. The table index is phase bits [31:18].
- R4: The sample for table index i is 512 + floor(511 × sin(2πi/16384)) for every i in 0..16383. After reset, `level_o` never reads 0.
- R5: `level_o` takes the value for the new phase on the clock edge that follows the strobe. At every other edge it holds its value.
- R6: `level_signed_o` always equals `level_o` with its MSB inverted, read as two's complement (that is, `level_o` − 512).
- R7: While `rst` is high, `sample_stb_o` is 0, `level_o` is 512 and `level_signed_o` is 0, and both accumulators return to 0.
- R8: A change of the tone code or rate code leaves the phase where it is. Later steps use the new code, with no jump, and a code of 0 freezes the phase.
- R9: With tone code 171798692, the 25th strobe brings the phase back to table index 0, so the sample is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code_i | input | ACC_W | Increment of the strobe rate accumulator |
| tone_code_i | input | ACC_W | Increment of the tone phase per strobe |
| sample_stb_o | output | 1 | One-clock sample strobe |
| level_o | output | SAMP_W | Offset-binary sine sample |
| level_signed_o | output | SAMP_W | Two's-complement sine sample |

## Verification
The bench builds the block with its default parameters: 32-bit accumulators, a 14-bit table index and 10-bit samples. A tone code of 2^18 then steps the index by one per strobe, and a rate code of 2^31 strobes every second clock. Together these walk all 16384 table positions, so every quadrant fold and both axis special cases are checked against the sine formula. The stated 2000/3500/3900 Hz codes, live code changes and long-window strobe counts for several rate codes cover the fractional behaviour.

// File: rtl/tone_dds_pkg.sv
package tone_dds_pkg;

  localparam real TONE_PI = 3.14159265358979323846;

  // Quadrant of the sine wave selected by the two top index bits.
  typedef enum logic [1:0] {
    QD_RISE   = 2'd0,
    QD_FALL   = 2'd1,
    QD_SINK   = 2'd2,
    QD_RETURN = 2'd3
  } quadrant_e;

  // floor(amp * sin(2*pi*idx / 2^addr_w)), evaluated at elaboration time.
  function automatic int sine_floor(int idx, int addr_w, int amp);
    real ang;
    ang = 2.0 * TONE_PI * real'(idx) / real'(1 << addr_w);
    return $rtoi($floor(real'(amp) * $sin(ang)));
  endfunction

endpackage

// File: rtl/tone_strobe_gen.sv
module tone_strobe_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] rate_code_i,
  output logic             wrap_o,
  output logic             strobe_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, rate_code_i};
    wrap_o = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      acc_q    <= sum[ACC_W-1:0];
      strobe_o <= sum[ACC_W];
    end
  end

  // R1: with the code below half scale on the wrap and the next add, strobes never touch
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && !rate_code_i[ACC_W-1] && $past(!rate_code_i[ACC_W-1])) |=> !strobe_o);

endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [ACC_W-1:0]  code_i,
  output logic [ADDR_W-1:0] index_next_o
);

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_next;

  always_comb begin
    phase_next   = phase_q + code_i;
    index_next_o = phase_next[ACC_W-1 -: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (step_i) phase_q <= phase_next;
  end

  // R3: the phase moves only on a wrap of the rate accumulator
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(phase_q));

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom
  import tone_dds_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [SAMP_W-2:0] mag_q,
  output quadrant_e         quad_q,
  output logic              axis_q
);

  localparam int QW     = ADDR_W - 2;
  localparam int QDEPTH = 1 << QW;
  localparam int AMP    = (1 << (SAMP_W - 1)) - 1;
  localparam logic [QW:0] TOP_IDX = (QW+1)'(QDEPTH);

  // Quarter wave, both ends included: QDEPTH + 1 words.
  logic [SAMP_W-2:0] qtab [0:QDEPTH];

  initial begin
    for (int j = 0; j <= QDEPTH; j++) begin
      int v;
      v = sine_floor(j, ADDR_W, AMP);
      qtab[j] = v[SAMP_W-2:0];
    end
  end

  quadrant_e      quad;
  logic [QW-1:0]  fine;
  logic [QW:0]    ridx;

  always_comb begin
    quad = quadrant_e'(index_i[ADDR_W-1 -: 2]);
    fine = index_i[QW-1:0];
    if (quad == QD_FALL || quad == QD_RETURN) ridx = TOP_IDX - {1'b0, fine};
    else                                      ridx = {1'b0, fine};
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) begin
      mag_q  <= qtab[ridx];
      quad_q <= quad;
      axis_q <= (fine == '0);
    end
  end

endmodule

// File: rtl/tone_dds.sv
module tone_dds
  import tone_dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 14,
  parameter int SAMP_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ACC_W-1:0]         rate_code_i,
  input  logic [ACC_W-1:0]         tone_code_i,
  output logic                     sample_stb_o,
  output logic [SAMP_W-1:0]        level_o,
  output logic signed [SAMP_W-1:0] level_signed_o
);

  localparam logic [SAMP_W-1:0] MID_L   = SAMP_W'(1 << (SAMP_W - 1));
  localparam logic [SAMP_W-1:0] MID_M1  = MID_L - SAMP_W'(1);
  localparam logic [SAMP_W-1:0] TROUGH  = SAMP_W'(1);

  logic              wrap;
  logic [ADDR_W-1:0] index_next;
  logic [SAMP_W-2:0] mag;
  quadrant_e         quad;
  logic              axis;
  logic [SAMP_W-1:0] level;

  tone_strobe_gen #(.ACC_W(ACC_W)) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .rate_code_i (rate_code_i),
    .wrap_o      (wrap),
    .strobe_o    (sample_stb_o)
  );

  tone_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .step_i       (wrap),
    .code_i       (tone_code_i),
    .index_next_o (index_next)
  );

  tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk     (clk),
    .rd_en_i (wrap),
    .index_i (index_next),
    .mag_q   (mag),
    .quad_q  (quad),
    .axis_q  (axis)
  );

  // Rebuild the full wave from the stored quarter.
  always_comb begin
    case (quad)
      QD_RISE, QD_FALL: level = MID_L + {1'b0, mag};
      QD_SINK:          level = axis ? MID_L  : MID_M1 - {1'b0, mag};
      QD_RETURN:        level = axis ? TROUGH : MID_M1 - {1'b0, mag};
      default:          level = MID_L;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o        <= MID_L;
      level_signed_o <= '0;
    end else if (sample_stb_o) begin
      level_o        <= level;
      level_signed_o <= {~level[SAMP_W-1], level[SAMP_W-2:0]};
    end
  end

  // R5: the sample only moves on the edge after a strobe
  a_r5_sample_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_stb_o |=> $stable(level_o));

  // R4: offset-binary output never reaches code 0
  a_r4_never_zero: assert property (@(posedge clk) disable iff (rst)
    level_o != '0);

endmodule

// File: tb/tone_dds_test.sv
`timescale 1ns/1ps
module tone_dds_test;

  localparam int ACC_W  = 32;
  localparam int ADDR_W = 14;
  localparam int SAMP_W = 10;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [ACC_W-1:0]         rate_code = '0;
  logic [ACC_W-1:0]         tone_code = '0;
  logic                     stb;
  logic [SAMP_W-1:0]        lvl;
  logic signed [SAMP_W-1:0] lvl_s;

  tone_dds #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) uut (
    .clk            (clk),
    .rst            (rst),
    .rate_code_i    (rate_code),
    .tone_code_i    (tone_code),
    .sample_stb_o   (stb),
    .level_o        (lvl),
    .level_signed_o (lvl_s)
  );

  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit pend = 1'b0;
  bit prev_stb = 1'b0;
  int k = 0;
  int last_exp = 512;
  logic [31:0] ph = '0;
  string tag = "R3";

  function automatic int ref_level(int i);
    return 512 + $rtoi($floor(511.0 * $sin(2.0 * 3.14159265358979323846 * real'(i) / 16384.0)));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference model, evaluated 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      if (pend) begin
        last_exp = ref_level(int'(ph[31:18]));
        check(int'(lvl) == last_exp, {tag, "/R4/R5 sample"}, lvl, last_exp);
        check(int'(lvl_s) == last_exp - 512, "R6 signed copy", lvl_s, last_exp - 512);
        pend = 1'b0;
      end else begin
        check(int'(lvl) == last_exp, "R5 hold", lvl, last_exp);
      end
      if (stb) begin
        check(!prev_stb || rate_code[31], "R1 adjacent strobes", 1, 0);
        ph = ph + tone_code;
        pend = 1'b1;
        k++;
      end
      prev_stb = stb;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(stb == 1'b0, "R7 strobe in reset", stb, 0);
    check(lvl == 10'd512, "R7 level in reset", lvl, 512);
    check(lvl_s == 0, "R7 signed in reset", lvl_s, 0);
    ph = '0; pend = 1'b0; prev_stb = 1'b0; k = 0; last_exp = 512;
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic rate_count(logic [31:0] c, int w, string req);
    longint exp;
    int cnt;
    rate_code = c;
    do_reset();
    cnt = 0;
    repeat (w) begin
      @(negedge clk);
      if (stb) cnt++;
    end
    exp = (longint'(w) * longint'(c)) >>> 32;
    check(longint'(cnt) == exp, req, cnt, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Exhaustive table walk: one index per strobe, strobe every other clock (R3, R4)
    rate_code = 32'h8000_0000;
    tone_code = 32'h0004_0000;
    tag = "R3";
    do_reset();
    wait (k >= 16386);
    repeat (4) @(negedge clk);

    // 2000 Hz code returns to index 0 after 25 strobes (R9)
    rate_code = 32'h4000_0000;
    tone_code = 32'd171798692;
    tag = "R9";
    do_reset();
    wait (k >= 25);
    @(posedge clk);
    #3;
    check(lvl == 10'd512, "R9 index 0 after 25 strobes", lvl, 512);
    wait (k >= 200);

    // Live code changes keep the phase (R8)
    tag = "R8";
    @(negedge clk) tone_code = 32'd300647711;
    wait (k >= 260);
    @(negedge clk) begin
      tone_code = 32'd335007449;
      rate_code = 32'h2AAA_AAAB;
    end
    wait (k >= 330);
    @(negedge clk) tone_code = '0;
    wait (k >= 360);
    repeat (8) @(negedge clk);

    // Strobe counts over fixed windows (R1, R2)
    tone_code = 32'd171798692;
    rate_count(32'h4000_0000, 1000, "R1 count quarter");
    rate_count(32'd1431655765, 300, "R1 count third");
    rate_count(32'd4294967, 20000, "R2 count 50 kHz");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule